// File: doc/BRIEF.md
# I2C Master Clock Generator with Stretch Support

This block produces the serial clock of an I2C master from the system clock. It also produces the timing strobes that a byte engine uses to move SDA and to sample it. The clock line is open-drain. The block pulls SCL low for the low phase and then lets it go. It does not start timing the high phase until the line, after a synchronizer and a selectable glitch filter, actually reads high. A slave that holds SCL low therefore stalls the clock for as long as it likes.

A 16-bit divider sets the length of each phase in system-clock cycles. A value of zero is treated as one. An 8-bit SDA delay places the SDA update strobe inside the low phase, counted from the start of SCL low. If the delay reaches past the phase, the strobe moves to the last low cycle. A 2-bit filter setting sets how many extra cycles a new synchronized level must persist before the block accepts it. While the block is disabled or in reset, SCL is released and all strobes stay quiet.

Top module: `i2c_scl_gen`

## Requirements
- R1: While `rstN` is low or `enable` is low, `sclDriveLow` is 0 and `sdaChange`, `sampleStrobe` and `bitEnd` are all 0.
- R2: The low phase holds `sclDriveLow` at 1 for max(D, 4+F) cycles. D is the effective divider and F is `filterSel`. The phase takes D cycles, but it is extended until the filtered line has been seen low.
- R3: A `divider` value of 0 behaves exactly like a value of 1.
- R4: The sampled `sclIn` passes two synchronizer flops. A changed level is then accepted only after it has persisted for F further cycles. The high phase therefore starts counting 4+F cycles after the line goes high.
- R5: While a slave holds SCL low after release, the block waits. Every cycle of the hold adds one cycle to the released phase, and the strobes of the high phase shift by the same amount.
- R6: Once the line is recognised high, the high phase lasts D cycles. The released phase (`sclDriveLow` = 0) therefore lasts 4+F+S+D cycles, where S is the stretch.
- R7: `sdaChange` pulses exactly once per low phase, on low-phase cycle min(`sdaDelay`, D-1), counting from 0 at the first low cycle. It is only ever 1 while SCL is driven low.
- R8: `sampleStrobe` pulses exactly once per released phase, on high-phase cycle floor(D/2). This is released-phase index 4+F+S+floor(D/2).
- R9: `bitEnd` pulses on the last released cycle. The next cycle starts a new low phase.
- R10: Dropping `enable` at any time releases SCL from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the clock generator |
| divider | input | 16 | Phase length in system cycles (0 means 1) |
| sdaDelay | input | 8 | SDA update offset into the low phase |
| filterSel | input | 2 | Extra stable cycles required by the SCL filter |
| sclIn | input | 1 | Level read from the SCL pin |
| sclDriveLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaChange | output | 1 | One-cycle strobe: SDA may change now |
| sampleStrobe | output | 1 | One-cycle strobe: sample SDA now (middle of high) |
| bitEnd | output | 1 | One-cycle strobe on the last cycle of a bit |

## Verification
SCL feedback reaches the controller through two synchronizer flops, F filter cycles and the state register. Each expected duration is therefore derived in the bench: 4+F cycles of latency plus the divider and any stretch, with the low phase bounded below by that same latency. The bench drives inputs and changes the slave hold on falling clock edges, and reads every output on falling edges. It counts run lengths and strobe positions as indices within each phase, so every check lands on the cycle the registered state makes visible. Disable is checked on the first falling edge after the rising edge that registers it.

// File: rtl/i2c_scl_gen_pkg.sv
package i2c_scl_gen_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LOW,
    PH_LOW_HOLD,
    PH_WAIT_HIGH,
    PH_HIGH
  } phase_e;

  // control -> datapath
  typedef struct packed {
    logic cntClr;
    logic inLow;
    logic inHigh;
  } ctrl_s;

  // datapath -> control
  typedef struct packed {
    logic cntLast;
    logic filtHigh;
  } stat_s;

endpackage

// File: rtl/i2c_scl_gen_datapath.sv
module i2c_scl_gen_datapath
  import i2c_scl_gen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DLY_W       = 8,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divider,
  input  logic [DLY_W-1:0]  sdaDelay,
  input  logic [FILT_W-1:0] filterSel,
  input  logic              sclIn,
  input  ctrl_s             ctrl,
  output stat_s             stat,
  output logic              sdaChange,
  output logic              sampleStrobe,
  output logic              bitEnd
);

  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  // synchronizer, reset to the idle-high bus level
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   syncOut;

  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], sclIn};
  end
  assign syncOut = syncQ[SYNC_STAGES-1];

  // stability filter: a new level must persist filterSel extra cycles
  logic              filtQ;
  logic [FILT_W-1:0] filtCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      filtQ   <= 1'b1;
      filtCnt <= '0;
    end else if (syncOut != filtQ) begin
      if (filtCnt == filterSel) begin
        filtQ   <= syncOut;
        filtCnt <= '0;
      end else begin
        filtCnt <= filtCnt + 1'b1;
      end
    end else begin
      filtCnt <= '0;
    end
  end

  // phase counter
  logic [DIV_W-1:0] divEff;
  logic [DIV_W-1:0] lastCnt;
  logic [DIV_W-1:0] midCnt;
  logic [DIV_W-1:0] dlyExt;
  logic [DIV_W-1:0] sdaTarget;
  logic [DIV_W-1:0] cnt;

  assign divEff    = (divider == '0) ? ONE : divider;
  assign lastCnt   = divEff - ONE;
  assign midCnt    = divEff >> 1;
  assign dlyExt    = DIV_W'(sdaDelay);
  assign sdaTarget = (dlyExt > lastCnt) ? lastCnt : dlyExt;

  always_ff @(posedge clk) begin
    if (!rstN)                            cnt <= '0;
    else if (ctrl.cntClr)                 cnt <= '0;
    else if (ctrl.inLow || ctrl.inHigh)   cnt <= cnt + ONE;
  end

  assign stat.cntLast  = (cnt == lastCnt);
  assign stat.filtHigh = filtQ;

  assign sdaChange    = ctrl.inLow  && (cnt == sdaTarget);
  assign sampleStrobe = ctrl.inHigh && (cnt == midCnt);
  assign bitEnd       = ctrl.inHigh && (cnt == lastCnt);

endmodule

// File: rtl/i2c_scl_gen_ctrl.sv
module i2c_scl_gen_ctrl
  import i2c_scl_gen_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  enable,
  input  stat_s stat,
  output ctrl_s ctrl,
  output logic  sclDriveLow
);

  phase_e phaseQ, phaseNext;
  logic   driveQ;

  always_comb begin
    phaseNext = phaseQ;
    unique case (phaseQ)
      PH_IDLE:      phaseNext = PH_LOW;
      PH_LOW:       if (stat.cntLast) phaseNext = stat.filtHigh ? PH_LOW_HOLD : PH_WAIT_HIGH;
      PH_LOW_HOLD:  if (!stat.filtHigh) phaseNext = PH_WAIT_HIGH;
      PH_WAIT_HIGH: if (stat.filtHigh) phaseNext = PH_HIGH;
      PH_HIGH:      if (stat.cntLast) phaseNext = PH_LOW;
      default:      phaseNext = PH_IDLE;
    endcase
    if (!enable) phaseNext = PH_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_IDLE;
      driveQ <= 1'b0;
    end else begin
      phaseQ <= phaseNext;
      driveQ <= (phaseNext == PH_LOW) || (phaseNext == PH_LOW_HOLD);
    end
  end

  assign ctrl.cntClr = (phaseNext != phaseQ);
  assign ctrl.inLow  = (phaseQ == PH_LOW);
  assign ctrl.inHigh = (phaseQ == PH_HIGH);
  assign sclDriveLow = driveQ;

endmodule

// File: rtl/i2c_scl_gen.sv
module i2c_scl_gen
  import i2c_scl_gen_pkg::*;
#(
  parameter int DIV_W       = 16,
  parameter int DLY_W       = 8,
  parameter int FILT_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [DIV_W-1:0]  divider,
  input  logic [DLY_W-1:0]  sdaDelay,
  input  logic [FILT_W-1:0] filterSel,
  input  logic              sclIn,
  output logic              sclDriveLow,
  output logic              sdaChange,
  output logic              sampleStrobe,
  output logic              bitEnd
);

  ctrl_s ctrlBus;
  stat_s statBus;

  i2c_scl_gen_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .stat        (statBus),
    .ctrl        (ctrlBus),
    .sclDriveLow (sclDriveLow)
  );

  i2c_scl_gen_datapath #(
    .DIV_W       (DIV_W),
    .DLY_W       (DLY_W),
    .FILT_W      (FILT_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .divider      (divider),
    .sdaDelay     (sdaDelay),
    .filterSel    (filterSel),
    .sclIn        (sclIn),
    .ctrl         (ctrlBus),
    .stat         (statBus),
    .sdaChange    (sdaChange),
    .sampleStrobe (sampleStrobe),
    .bitEnd       (bitEnd)
  );

endmodule

// File: rtl/i2c_scl_gen_checker.sv
module i2c_scl_gen_checker (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclDriveLow,
  input logic sdaChange,
  input logic sampleStrobe,
  input logic bitEnd
);

  p_release_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !sclDriveLow);

  p_quiet_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !(sdaChange || sampleStrobe || bitEnd));

  p_low_min_r2: assert property (@(posedge clk) disable iff (!rstN || !enable)
    $rose(sclDriveLow) |=> sclDriveLow);

  p_sda_in_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    sdaChange |-> sclDriveLow);

  p_sda_sample_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sdaChange, sampleStrobe}));

  p_sample_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    sampleStrobe |-> !sclDriveLow);

  p_end_then_low_r9: assert property (@(posedge clk) disable iff (!rstN || !enable)
    bitEnd |=> sclDriveLow);

endmodule

bind i2c_scl_gen i2c_scl_gen_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .enable       (enable),
  .sclDriveLow  (sclDriveLow),
  .sdaChange    (sdaChange),
  .sampleStrobe (sampleStrobe),
  .bitEnd       (bitEnd)
);

// File: tb/test_i2c_scl_gen.sv
`timescale 1ns/1ps
module test_i2c_scl_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        enable = 1'b0;
  logic [15:0] divider = '0;
  logic [7:0]  sdaDelay = '0;
  logic [1:0]  filterSel = '0;
  logic        hold = 1'b0;
  logic        sclIn;
  logic        sclDriveLow, sdaChange, sampleStrobe, bitEnd;

  int nChk = 0;
  int nBad = 0;

  always #2.5 clk = ~clk;

  assign sclIn = ~(sclDriveLow | hold);

  i2c_scl_gen i_i2c_scl_gen (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .divider      (divider),
    .sdaDelay     (sdaDelay),
    .filterSel    (filterSel),
    .sclIn        (sclIn),
    .sclDriveLow  (sclDriveLow),
    .sdaChange    (sdaChange),
    .sampleStrobe (sampleStrobe),
    .bitEnd       (bitEnd)
  );

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic quietCheck(input string req);
    check(req, int'({sclDriveLow, sdaChange, sampleStrobe, bitEnd}), 0);
  endtask

  // three full bits under one configuration; s = slave stretch cycles
  task automatic runCfg(input int dv, input int k, input int sd, input int s);
    int de, lat, expLow, expRel;
    int low, rel, sdaIdx, sdaHits, smpIdx, smpHits, endIdx, endHits;
    de     = (dv == 0) ? 1 : dv;
    lat    = 4 + k;
    expLow = (de > lat) ? de : lat;
    expRel = lat + s + de;
    divider   = 16'(dv);
    filterSel = 2'(k);
    sdaDelay  = 8'(sd);
    enable    = 1'b1;
    while (!sclDriveLow) @(negedge clk);
    for (int p = 0; p < 3; p++) begin
      low = 0; sdaHits = 0; sdaIdx = -1;
      while (sclDriveLow) begin
        if (sdaChange) begin sdaHits++; sdaIdx = low; end
        low++;
        @(negedge clk);
      end
      rel = 0; smpHits = 0; smpIdx = -1; endHits = 0; endIdx = -1;
      while (!sclDriveLow) begin
        if (sampleStrobe) begin smpHits++; smpIdx = rel; end
        if (bitEnd) begin endHits++; endIdx = rel; end
        if (rel == 0 && s > 0) hold = 1'b1;
        if (rel == s) hold = 1'b0;
        rel++;
        @(negedge clk);
      end
      if (sdaHits != 1) sdaIdx = -1;
      if (smpHits != 1) smpIdx = -1;
      if (endHits != 1) endIdx = -1;
      check((dv == 0) ? "R3 low phase, zero divider" : "R2 low phase", low, expLow);
      check((s > 0) ? "R5 stretched released phase" : "R4 R6 released phase", rel, expRel);
      check("R7 sda strobe index", sdaIdx, (sd < de - 1) ? sd : de - 1);
      check("R8 sample strobe index", smpIdx, lat + s + de / 2);
      check("R9 bit end index", endIdx, expRel - 1);
    end
    enable = 1'b0;
    @(negedge clk);
    quietCheck("R1 disabled quiet");
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    int dvs[6] = '{0, 1, 2, 3, 6, 9};
    int sds[3] = '{0, 2, 255};
    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      quietCheck("R1 reset quiet");
    end
    rstN = 1'b1;
    repeat (4) begin
      @(negedge clk);
      quietCheck("R1 enable low quiet");
    end

    foreach (dvs[i])
      for (int k = 0; k < 4; k++)
        foreach (sds[j])
          runCfg(dvs[i], k, sds[j], 0);

    // R5: slave stretching
    runCfg(3, 0, 1, 5);
    runCfg(7, 2, 4, 20);
    runCfg(1, 3, 0, 9);
    runCfg(12, 1, 300 % 256, 3);

    // R10: disable in the middle of a low phase
    divider = 16'd20; filterSel = 2'd0; sdaDelay = 8'd10;
    enable = 1'b1;
    while (!sclDriveLow) @(negedge clk);
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R10 release after disable in low", int'(sclDriveLow), 0);
    repeat (10) begin
      @(negedge clk);
      quietCheck("R1 quiet after disable");
    end

    // R10: disable in the middle of the high phase
    enable = 1'b1;
    while (!sclDriveLow) @(negedge clk);
    while (sclDriveLow) @(negedge clk);
    repeat (8) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    quietCheck("R10 quiet after disable in high");
    repeat (6) begin
      @(negedge clk);
      check("R10 stays released", int'(sclDriveLow), 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule